// File: doc/BRIEF.md
# Multi-Source System Reset Controller

This block merges seven independent reset requests into one active-high system reset for the rest of the chip. The requests are power-on, brown-out, a filtered external clear pin, a software reset strobe, a watchdog expiry, a trap conflict, and an illegal-opcode or uninitialized-register event. All of them arrive as digital signals. The output rises on the clock edge after any request is seen. After the last request goes away, the output is held for a fixed number of further cycles, so that every downstream register leaves reset on the same edge.

A 16-bit cause register records which kinds of reset occurred. Each cause owns one bit, and the bits are sticky across resets other than power-on. A power-on request leaves only the power-on bit set. Software reads the register through a plain read/write port and may set or clear any implemented bit. Such a write only changes the record: it never produces a reset. Writes are ignored while the system reset is held. When hardware sets a cause bit in the same cycle as a software write, the hardware setting wins.

The external clear pin is active low. It passes through a two-stage synchronizer and then a filter that needs several consecutive low samples before it counts as a request.

Top module: `reset_hub`

## Requirements
- R1: `sys_rst` is 1 after the first rising clock edge at which any request is sampled active. The requests are `por_req`, `bor_req`, `swrst_req`, `wdt_req`, `trap_req`, `illop_req`, or the filtered clear pin.
- R2: After the last clock edge at which any request is sampled active, `sys_rst` stays 1 for exactly 16 more sampled cycles and then returns to 0.
- R3: Each cause sets its own bit of `reg_rdata`: bit 0 power-on, bit 1 brown-out, bit 4 watchdog, bit 6 software strobe, bit 7 clear pin, bit 14 illegal-opcode/uninitialized-register, bit 15 trap conflict.
- R4: A power-on request makes the register read exactly 16'h0001, whatever its prior value and whatever other requests are active in the same cycle.
- R5: Bits 2, 3, 5 and 8 to 13 always read 0, and writing 1 to them has no effect.
- R6: With `sys_rst` at 0, asserting `reg_wr_en` loads `reg_wdata` into the implemented bits, and the new value appears on `reg_rdata` after that edge. A write never asserts `sys_rst`.
- R7: A reset from any cause other than power-on leaves every other cause bit unchanged and sets its own bit.
- R8: The pin `mclr_pin_n` is synchronized through 2 stages. It causes a reset only after 4 consecutive low synchronized samples. A low pulse of 4 cycles raises `sys_rst` 7 edges after the first low sample, while a low pulse of 3 cycles causes no reset and no status change.
- R9: A register write presented while `sys_rst` is 1 is ignored.
- R10: When a cause is set by hardware in the same cycle as a software write that clears its bit, the bit ends up set.
- R11: A brown-out sets bit 1 only and clears no other bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_req | input | 1 | Power-on request, active high; also resets the block's own state |
| bor_req | input | 1 | Brown-out request, active high |
| mclr_pin_n | input | 1 | External clear pin, active low, asynchronous |
| swrst_req | input | 1 | Software reset strobe |
| wdt_req | input | 1 | Watchdog expiry request |
| trap_req | input | 1 | Trap-conflict request |
| illop_req | input | 1 | Illegal-opcode or uninitialized-register request |
| reg_wr_en | input | 1 | Cause-register write enable |
| reg_wdata | input | 16 | Cause-register write data |
| reg_rdata | output | 16 | Cause-register contents |
| sys_rst | output | 1 | Active-high system reset |

## Verification
A stuck or miscounted hold counter shows at `sys_rst` as a release one or more cycles early or late, within 17 cycles of the last request. A wrong filter count appears on `sys_rst` within 7 cycles of a 3- or 4-cycle pin pulse. A corrupted cause bit, a lost sticky value or a write accepted during reset is visible on `reg_rdata` on the very next cycle, because the register is read out directly. The bench compares both outputs against a behavioural model every cycle, so any of these shows up at the first cycle where it diverges.

// File: rtl/rsthub_pkg.sv
package rsthub_pkg;

    localparam int STAT_W = 16;

    localparam int BIT_POR   = 0;
    localparam int BIT_BOR   = 1;
    localparam int BIT_WDT   = 4;
    localparam int BIT_SW    = 6;
    localparam int BIT_PIN   = 7;
    localparam int BIT_ILLOP = 14;
    localparam int BIT_TRAP  = 15;

    localparam logic [STAT_W-1:0] IMPL_MASK =
        (STAT_W'(1) << BIT_POR)   | (STAT_W'(1) << BIT_BOR) |
        (STAT_W'(1) << BIT_WDT)   | (STAT_W'(1) << BIT_SW)  |
        (STAT_W'(1) << BIT_PIN)   | (STAT_W'(1) << BIT_ILLOP) |
        (STAT_W'(1) << BIT_TRAP);

    localparam logic [STAT_W-1:0] POR_ONLY = STAT_W'(1) << BIT_POR;

    typedef struct packed {
        logic trap;
        logic illop;
        logic pin;
        logic sw;
        logic wdt;
        logic bor;
        logic por;
    } cause_t;

    function automatic logic [STAT_W-1:0] cause_bits(input cause_t c);
        logic [STAT_W-1:0] v;
        v = '0;
        v[BIT_POR]   = c.por;
        v[BIT_BOR]   = c.bor;
        v[BIT_WDT]   = c.wdt;
        v[BIT_SW]    = c.sw;
        v[BIT_PIN]   = c.pin;
        v[BIT_ILLOP] = c.illop;
        v[BIT_TRAP]  = c.trap;
        return v;
    endfunction

    function automatic logic any_cause(input cause_t c);
        return |c;
    endfunction

endpackage

// File: rtl/rsthub_pin_filter.sv
module rsthub_pin_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic hit
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          cnt_q;
    logic                   pin_s;

    generate
        for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) sync_q[0] <= 1'b1;
                    else     sync_q[0] <= pin_n;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (rst) sync_q[s] <= 1'b1;
                    else     sync_q[s] <= sync_q[s-1];
                end
            end
        end
    endgenerate

    assign pin_s = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst || pin_s)
            cnt_q <= '0;
        else if (cnt_q != CW'(FILT_LEN))
            cnt_q <= cnt_q + CW'(1);
    end

    assign hit = (cnt_q == CW'(FILT_LEN));

    // R8: an accepted pin request implies the last synchronized sample was low
    a_r8_filter_low: assert property (@(posedge clk) disable iff (rst)
        hit |-> $past(!pin_s));

    // R8: a high synchronized sample always drops an accepted request
    a_r8_high_clears: assert property (@(posedge clk) disable iff (rst)
        pin_s |=> !hit);

endmodule

// File: rtl/rsthub_stretch.sv
module rsthub_stretch #(
    parameter int HOLD = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic any_req,
    output logic sys_rst
);
    localparam int HW = $clog2(HOLD + 1);
    localparam int QW = $clog2(HOLD + 2);

    logic [HW-1:0] hold_q;
    logic          rst_q;

    always_ff @(posedge clk) begin
        if (rst || any_req) begin
            rst_q  <= 1'b1;
            hold_q <= HW'(HOLD);
        end else if (hold_q != '0) begin
            rst_q  <= 1'b1;
            hold_q <= hold_q - HW'(1);
        end else begin
            rst_q  <= 1'b0;
        end
    end

    assign sys_rst = rst_q;

    // checker-side count of quiet cycles since the last request
    logic [QW-1:0] quiet_q;
    always_ff @(posedge clk) begin
        if (rst || any_req)
            quiet_q <= '0;
        else if (quiet_q != QW'(HOLD + 1))
            quiet_q <= quiet_q + QW'(1);
    end

    // R1: any request raises the system reset on the next edge
    a_r1_req_raises: assert property (@(posedge clk) disable iff (rst)
        any_req |=> sys_rst);

    // R2: release happens only after exactly HOLD+1 request-free edges
    a_r2_release_window: assert property (@(posedge clk) disable iff (rst)
        $fell(sys_rst) |-> (quiet_q == QW'(HOLD + 1)));

    // R2: no early release while the quiet window is still open
    a_r2_held_in_window: assert property (@(posedge clk) disable iff (rst)
        (quiet_q < QW'(HOLD + 1)) |-> sys_rst);

endmodule

// File: rtl/rsthub_status.sv
module rsthub_status
    import rsthub_pkg::*;
(
    input  logic              clk,
    input  logic              por,
    input  cause_t            hits,
    input  logic              sys_rst,
    input  logic              wr_en,
    input  logic [STAT_W-1:0] wdata,
    output logic [STAT_W-1:0] status
);
    logic [STAT_W-1:0] status_q;
    logic [STAT_W-1:0] base_d;
    logic [STAT_W-1:0] set_d;
    logic              wr_ok;

    always_comb begin
        wr_ok  = wr_en && !sys_rst;
        base_d = wr_ok ? (wdata & IMPL_MASK) : status_q;
        set_d  = cause_bits(hits);
    end

    always_ff @(posedge clk) begin
        if (por) status_q <= POR_ONLY;
        else     status_q <= base_d | set_d;
    end

    assign status = status_q;

    // R4: power-on leaves only its own bit
    a_r4_por_only: assert property (@(posedge clk)
        por |=> (status == 16'h0001));

    // R5: reserved bits never read as one
    a_r5_reserved_zero: assert property (@(posedge clk) disable iff (por)
        (status & ~IMPL_MASK) == '0);

    // R9: with reset held and no cause active, the register does not move
    a_r9_write_ignored: assert property (@(posedge clk) disable iff (por)
        (sys_rst && !any_cause(hits)) |=> $stable(status));

    // R10: hardware-set bits are present after the edge regardless of writes
    a_r10_hw_wins: assert property (@(posedge clk) disable iff (por)
        any_cause(hits) |=> ((status & $past(set_d)) == $past(set_d)));

endmodule

// File: rtl/reset_hub.sv
module reset_hub
    import rsthub_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4,
    parameter int HOLD_CYCLES = 16
) (
    input  logic        clk,
    input  logic        por_req,
    input  logic        bor_req,
    input  logic        mclr_pin_n,
    input  logic        swrst_req,
    input  logic        wdt_req,
    input  logic        trap_req,
    input  logic        illop_req,
    input  logic        reg_wr_en,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        sys_rst
);
    cause_t hits;
    logic   pin_hit;
    logic   any_req;

    rsthub_pin_filter #(
        .SYNC_STAGES (SYNC_STAGES),
        .FILT_LEN    (FILT_LEN)
    ) u_filter (
        .clk   (clk),
        .rst   (por_req),
        .pin_n (mclr_pin_n),
        .hit   (pin_hit)
    );

    always_comb begin
        hits.por   = por_req;
        hits.bor   = bor_req;
        hits.pin   = pin_hit;
        hits.sw    = swrst_req;
        hits.wdt   = wdt_req;
        hits.trap  = trap_req;
        hits.illop = illop_req;
        any_req    = any_cause(hits);
    end

    rsthub_stretch #(
        .HOLD (HOLD_CYCLES)
    ) u_stretch (
        .clk     (clk),
        .rst     (por_req),
        .any_req (any_req),
        .sys_rst (sys_rst)
    );

    rsthub_status u_status (
        .clk     (clk),
        .por     (por_req),
        .hits    (hits),
        .sys_rst (sys_rst),
        .wr_en   (reg_wr_en),
        .wdata   (reg_wdata),
        .status  (reg_rdata)
    );

    // R6: a software write alone never brings the system into reset
    a_r6_write_no_reset: assert property (@(posedge clk) disable iff (por_req)
        (!sys_rst && !any_req && reg_wr_en) |=> !sys_rst);

    // R7: a non-power-on cause keeps other bits set (no write in flight)
    a_r7_sticky: assert property (@(posedge clk) disable iff (por_req)
        (any_req && !(reg_wr_en && !sys_rst)) |=> ((reg_rdata & $past(reg_rdata)) == $past(reg_rdata)));

endmodule

// File: tb/tb_reset_hub.sv
module tb_reset_hub;
    logic        clk = 1'b0;
    logic        por_req = 1'b1;
    logic        bor_req = 1'b0;
    logic        mclr_pin_n = 1'b1;
    logic        swrst_req = 1'b0;
    logic        wdt_req = 1'b0;
    logic        trap_req = 1'b0;
    logic        illop_req = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        sys_rst;

    integer checks = 0;
    integer failures = 0;

    always #2 clk = ~clk;

    reset_hub dut (
        .clk(clk), .por_req(por_req), .bor_req(bor_req), .mclr_pin_n(mclr_pin_n),
        .swrst_req(swrst_req), .wdt_req(wdt_req), .trap_req(trap_req),
        .illop_req(illop_req), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .sys_rst(sys_rst)
    );

    // behavioural reference model
    bit     pin_q[$];
    integer m_cnt = 0;
    integer m_hold = 0;
    bit     m_sys = 1'b1;
    bit [15:0] m_stat = 16'h0001;
    bit     m_valid = 1'b0;

    always @(posedge clk) begin
        bit pin_out;
        bit hit;
        bit anyr;
        bit [15:0] nx;
        hit  = (m_cnt == 4);
        anyr = por_req | bor_req | swrst_req | wdt_req | trap_req | illop_req | hit;
        if (por_req) begin
            pin_q = '{1'b1, 1'b1};
            m_cnt = 0;
            m_hold = 16;
            m_sys = 1'b1;
            m_stat = 16'h0001;
        end else begin
            nx = m_stat;
            if (reg_wr_en && !m_sys) nx = reg_wdata & 16'hC0D3;
            if (bor_req)   nx[1]  = 1'b1;
            if (wdt_req)   nx[4]  = 1'b1;
            if (swrst_req) nx[6]  = 1'b1;
            if (hit)       nx[7]  = 1'b1;
            if (illop_req) nx[14] = 1'b1;
            if (trap_req)  nx[15] = 1'b1;
            m_stat = nx;
            pin_out = pin_q[$];
            if (pin_out) m_cnt = 0;
            else if (m_cnt < 4) m_cnt = m_cnt + 1;
            void'(pin_q.pop_back());
            pin_q.push_front(mclr_pin_n);
            if (anyr) begin
                m_sys = 1'b1; m_hold = 16;
            end else if (m_hold != 0) begin
                m_sys = 1'b1; m_hold = m_hold - 1;
            end else begin
                m_sys = 1'b0;
            end
        end
        m_valid = 1'b1;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            failures = failures + 1;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model (R1 R2 on sys_rst, R3 on register)
    always @(negedge clk) begin
        if (m_valid) begin
            chk("R1/R2 model sys_rst", {31'b0, sys_rst}, {31'b0, m_sys});
            chk("R3 model reg_rdata", {16'b0, reg_rdata}, {16'b0, m_stat});
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // drop all requests, then count sampled cycles with sys_rst high
    task automatic count_release(input string tag);
        int highs;
        highs = 0;
        for (int i = 0; i < 40; i++) begin
            tick(1);
            if (sys_rst) highs++;
        end
        chk(tag, highs, 16);
    endtask

    task automatic sw_write(input logic [15:0] v);
        reg_wr_en = 1'b1; reg_wdata = v;
        tick(1);
        reg_wr_en = 1'b0; reg_wdata = 16'h0;
    endtask

    bit done = 1'b0;

    initial begin
        fork
            begin
                @(negedge clk);
                tick(3);
                // R4: reset state under power-on
                chk("R4 por value", {16'b0, reg_rdata}, 32'h0001);
                chk("R1 por asserts", {31'b0, sys_rst}, 1);
                por_req = 1'b0;
                count_release("R2 hold after por");
                chk("R2 released", {31'b0, sys_rst}, 0);

                // R6 software write, no reset
                sw_write(16'h00D2);
                chk("R6 write value", {16'b0, reg_rdata}, 32'h00D2);
                chk("R6 no reset from write", {31'b0, sys_rst}, 0);
                // R5 reserved bits
                sw_write(16'hFFFF);
                chk("R5 reserved masked", {16'b0, reg_rdata}, 32'hC0D3);
                sw_write(16'h0040);
                chk("R6 clear others", {16'b0, reg_rdata}, 32'h0040);

                // R11 / R7 brown-out keeps bit 6
                bor_req = 1'b1; tick(1); bor_req = 1'b0;
                chk("R11 brown-out bit only", {16'b0, reg_rdata}, 32'h0042);
                chk("R1 brown-out raises", {31'b0, sys_rst}, 1);
                // R9 write during reset ignored
                sw_write(16'h0000);
                chk("R9 write ignored", {16'b0, reg_rdata}, 32'h0042);
                tick(20);
                chk("R2 released after brown-out", {31'b0, sys_rst}, 0);

                // R10 hardware beats a clearing write
                wdt_req = 1'b1; reg_wr_en = 1'b1; reg_wdata = 16'h0000;
                tick(1);
                wdt_req = 1'b0; reg_wr_en = 1'b0;
                chk("R10 hw wins", {16'b0, reg_rdata}, 32'h0010);
                tick(20);

                // R3 / R7 each cause, stretched hold with a multi-cycle request
                sw_write(16'h0000);
                swrst_req = 1'b1; tick(1); swrst_req = 1'b0;
                chk("R3 software bit 6", {16'b0, reg_rdata}, 32'h0040);
                tick(20);
                trap_req = 1'b1; tick(5); trap_req = 1'b0;
                chk("R7 trap keeps bit 6", {16'b0, reg_rdata}, 32'h8040);
                count_release("R2 hold after long trap");
                illop_req = 1'b1; tick(1); illop_req = 1'b0;
                chk("R3 illegal-op bit 14", {16'b0, reg_rdata}, 32'hC040);
                tick(20);
                sw_write(16'h0000);

                // R8 glitch of 3 cycles ignored
                mclr_pin_n = 1'b0; tick(3); mclr_pin_n = 1'b1;
                tick(10);
                chk("R8 short pulse no reset", {31'b0, sys_rst}, 0);
                chk("R8 short pulse no status", {16'b0, reg_rdata}, 32'h0000);
                // R8 4-cycle pulse accepted, exact latency
                mclr_pin_n = 1'b0; tick(4); mclr_pin_n = 1'b1;
                tick(2);
                chk("R8 not yet at edge 6", {31'b0, sys_rst}, 0);
                tick(1);
                chk("R8 reset at edge 7", {31'b0, sys_rst}, 1);
                chk("R8 pin bit 7", {16'b0, reg_rdata}, 32'h0080);
                tick(20);

                // R4 power-on wipes with a concurrent brown-out
                sw_write(16'h80D2);
                por_req = 1'b1; bor_req = 1'b1; tick(1); bor_req = 1'b0;
                chk("R4 por wipes", {16'b0, reg_rdata}, 32'h0001);
                tick(2); por_req = 1'b0;
                count_release("R2 hold after second por");
                tick(2);
                done = 1'b1;
            end
            begin
                repeat (100000) @(posedge clk);
                if (!done) begin
                    checks = checks + 1;
                    failures = failures + 1;
                    $display("FAIL watchdog expired");
                end
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule